// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block watches the byte stream of an incoming Ethernet frame and decides, from the destination address in its first six bytes, whether the frame is kept or dropped and whether it counts as an address miss. Bytes arrive one per cycle when `in_valid` is high. `in_sof` marks the first byte of a frame and `in_eof` marks the last. The station address, a 64-bit hash table and three mode bits (reject broadcast, hash individual addresses, promiscuous) are static inputs that the surrounding logic holds.

The address is not stored. Three values build up byte by byte: an all-ones flag for broadcast, a mismatch flag against the station address, and a running CRC-32. The CRC uses the reflected form of polynomial 0x04C11DB7, takes each byte least-significant bit first, starts from all ones and is inverted at the end. The decision is registered and goes out as a single `dec_valid` pulse. It comes one cycle after the sixth address byte, or one cycle after the end-of-frame byte when the frame is shorter than six bytes.

The state machine has three states:
- `ST_IDLE`: no frame is open.
- `ST_ADDR`: address bytes are being collected.
- `ST_DONE`: the decision has been made and the rest of the frame is being skipped.

It has these transitions:
- **start**: a valid byte with `in_sof` from any state. It enters `ST_ADDR`, or goes straight to `ST_DONE` or `ST_IDLE` when that byte already ends the address or the frame.
- **collect**: `ST_ADDR` to `ST_ADDR` on a valid byte that is neither the sixth nor the last.
- **decide**: `ST_ADDR` to `ST_DONE` on the sixth byte.
- **runt**: `ST_ADDR` to `ST_IDLE` on an end-of-frame byte that comes before the sixth byte.
- **tail**: `ST_DONE` to `ST_IDLE` on the end-of-frame byte.

Top module: `rx_addr_filter`

## Requirements
- R1: After reset, `dec_valid`, `dec_accept` and `dec_miss` are all 0.
- R2: For a frame of six or more bytes, `dec_valid` is high for exactly one cycle: the cycle after the sixth valid byte. Bytes after the sixth, up to the next start of frame, produce no further decision.
- R3: A destination of six 0xFF bytes is a broadcast. It is a miss when `mode_no_bcast` is 1 and a hit otherwise. This test takes priority over the hash and exact tests.
- R4: A non-broadcast destination goes to the hash test when bit 0 of its first byte is 1 or when `mode_ind_hash` is 1. The index is bits 31:26 of the final CRC over the six address bytes. Index values 0 to 31 select that bit of `hash_lo`, and 32 to 63 select bit (index-32) of `hash_hi`. A 0 bit is a miss.
- R5: Any other destination is compared exactly. Byte 0 must equal `station_hi[15:8]` and byte 1 must equal `station_hi[7:0]`. Bytes 2, 3, 4 and 5 must equal `station_lo[31:24]`, `[23:16]`, `[15:8]` and `[7:0]`. Any difference is a miss.
- R6: A frame whose end-of-frame byte is byte 1 to 5 gets a decision one cycle after that byte, and that decision is a miss.
- R7: `dec_accept` is 1 for a hit. For a miss it equals the promiscuous mode bit. `dec_miss` reports the miss in either case.
- R8: The mode bits are taken on the start-of-frame byte. Changes later in the frame do not affect that frame's decision.
- R9: A start-of-frame byte in the middle of an address restarts collection, and the bytes before it are discarded.
- R10: Cycles with `in_valid` low are not counted as bytes and never produce a decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present |
| in_sof | input | 1 | This byte is the first of a frame |
| in_eof | input | 1 | This byte is the last of a frame |
| in_byte | input | 8 | Frame byte |
| station_hi | input | 16 | Station address bytes 0 (15:8) and 1 (7:0) |
| station_lo | input | 32 | Station address bytes 2..5, from bits 31:24 down |
| hash_lo | input | 32 | Hash table bits for indices 0..31 |
| hash_hi | input | 32 | Hash table bits for indices 32..63 |
| mode_no_bcast | input | 1 | Broadcast destinations count as a miss |
| mode_ind_hash | input | 1 | Individual addresses use the hash test |
| mode_promisc | input | 1 | Missed frames are accepted |
| dec_valid | output | 1 | Single-cycle decision strobe |
| dec_accept | output | 1 | Frame is kept |
| dec_miss | output | 1 | Destination did not match |

## Verification
The bench walks a table of frames through a reference model. The model computes the CRC index its own way and checks the exact cycle of each decision. The frames include broadcasts with and without rejection, which a filter that tested hash before broadcast would send to the hash table. They include multicast and hashed unicast addresses whose index bits are set or clear, which exposes any bit-order or inversion slip in the CRC. They also include a station address off by one byte at either end, and runts of three and five bytes, which a filter deciding only on the sixth byte would never answer. Directed tests change the promiscuous bit mid-frame, restart a frame with a new start byte, insert idle cycles between bytes, send a long frame tail, and send bytes that have no start marker. A design that resampled modes, counted idle cycles or decided twice per frame would fail these tests.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
    localparam int ADDR_BYTES = 6;
    localparam int BYTE_W     = 8;
    localparam int CRC_W      = 32;
    localparam int HASH_BITS  = 64;
    localparam int HASH_IDX_W = $clog2(HASH_BITS);
    localparam int CNT_W      = $clog2(ADDR_BYTES);
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DONE = 2'd2
    } rxf_state_e;

    typedef struct packed {
        logic promisc;
        logic ind_hash;
        logic no_bcast;
    } rxf_mode_t;
endpackage

// File: rtl/rxf_crc_byte.sv
module rxf_crc_byte #(
    parameter int          W    = rxf_pkg::CRC_W,
    parameter int          DW   = rxf_pkg::BYTE_W,
    parameter logic [31:0] POLY = rxf_pkg::CRC_POLY_REFL
) (
    input  logic [W-1:0]  crc_in,
    input  logic [DW-1:0] data,
    output logic [W-1:0]  crc_out
);
    logic [W-1:0] chain [0:DW];

    assign chain[0] = crc_in;

    generate
        for (genvar i = 0; i < DW; i++) begin : g_bit
            assign chain[i+1] = (chain[i] >> 1) ^
                                (((chain[i][0] ^ data[i]) == 1'b1) ? POLY[W-1:0] : '0);
        end
    endgenerate

    assign crc_out = chain[DW];
endmodule

// File: rtl/rxf_hash_pick.sv
module rxf_hash_pick #(
    parameter int BITS = rxf_pkg::HASH_BITS,
    localparam int IDX_W = $clog2(BITS)
) (
    input  logic [IDX_W-1:0] crc_top,
    input  logic [BITS-1:0]  table_bits,
    output logic             hit
);
    logic [IDX_W-1:0] idx;

    assign idx = ~crc_top;
    assign hit = table_bits[idx];
endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic [7:0]  in_byte,
    input  logic [15:0] station_hi,
    input  logic [31:0] station_lo,
    input  logic [31:0] hash_lo,
    input  logic [31:0] hash_hi,
    input  logic        mode_no_bcast,
    input  logic        mode_ind_hash,
    input  logic        mode_promisc,
    output logic        dec_valid,
    output logic        dec_accept,
    output logic        dec_miss
);
    import rxf_pkg::*;

    localparam int             LAST_I   = ADDR_BYTES - 1;
    localparam logic [CNT_W-1:0] LAST_POS = LAST_I[CNT_W-1:0];
    localparam int             ST_W     = ADDR_BYTES * BYTE_W;

    rxf_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, pos;
    logic [CRC_W-1:0] crc_q, crc_d, crc_in, crc_next;
    logic             bc_q, bc_d, bc_next;
    logic             mm_q, mm_d, mm_next;
    logic             mc_q, mc_d, mc_eff;
    rxf_mode_t        mode_q, mode_d, mode_in, mode_eff;
    logic             take, start, hash_hit, addr_miss;
    logic [ST_W-1:0]  station;
    logic [BYTE_W-1:0] exp_byte;
    logic             dv_d, acc_d, miss_d;

    assign mode_in  = '{promisc: mode_promisc, ind_hash: mode_ind_hash, no_bcast: mode_no_bcast};
    assign start    = in_valid && in_sof;
    assign take     = start || (in_valid && state_q == ST_ADDR);
    assign pos      = in_sof ? '0 : cnt_q;
    assign mode_eff = in_sof ? mode_in : mode_q;
    assign station  = {station_hi, station_lo};

    always_comb begin
        exp_byte = '0;
        for (int k = 0; k < ADDR_BYTES; k++) begin
            if (pos == k[CNT_W-1:0]) exp_byte = station[(ADDR_BYTES-1-k)*BYTE_W +: BYTE_W];
        end
    end

    assign crc_in  = in_sof ? '1 : crc_q;
    assign bc_next = (in_sof ? 1'b1 : bc_q) & (in_byte == 8'hFF);
    assign mm_next = (in_sof ? 1'b0 : mm_q) | (in_byte != exp_byte);
    assign mc_eff  = (pos == '0) ? in_byte[0] : mc_q;

    rxf_crc_byte u_crc (
        .crc_in  (crc_in),
        .data    (in_byte),
        .crc_out (crc_next)
    );

    rxf_hash_pick #(.BITS(HASH_BITS)) u_hash (
        .crc_top    (crc_next[CRC_W-1 -: HASH_IDX_W]),
        .table_bits ({hash_hi, hash_lo}),
        .hit        (hash_hit)
    );

    always_comb begin
        if (bc_next)                         addr_miss = mode_eff.no_bcast;
        else if (mc_eff || mode_eff.ind_hash) addr_miss = !hash_hit;
        else                                 addr_miss = mm_next;
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        crc_d   = crc_q;
        bc_d    = bc_q;
        mm_d    = mm_q;
        mc_d    = mc_q;
        mode_d  = start ? mode_in : mode_q;
        dv_d    = 1'b0;
        acc_d   = dec_accept;
        miss_d  = dec_miss;
        if (take) begin
            crc_d = crc_next;
            bc_d  = bc_next;
            mm_d  = mm_next;
            mc_d  = mc_eff;
            if (pos == LAST_POS) begin
                state_d = ST_DONE;
                dv_d    = 1'b1;
                miss_d  = addr_miss;
                acc_d   = !addr_miss || mode_eff.promisc;
            end else if (in_eof) begin
                state_d = ST_IDLE;
                dv_d    = 1'b1;
                miss_d  = 1'b1;
                acc_d   = mode_eff.promisc;
            end else begin
                state_d = ST_ADDR;
                cnt_d   = pos + 1'b1;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_ADDR: state_d = ST_ADDR;
                ST_DONE: if (in_valid && in_eof) state_d = ST_IDLE;
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            crc_q   <= '1;
            bc_q    <= 1'b0;
            mm_q    <= 1'b0;
            mc_q    <= 1'b0;
            mode_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            crc_q   <= crc_d;
            bc_q    <= bc_d;
            mm_q    <= mm_d;
            mc_q    <= mc_d;
            mode_q  <= mode_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dec_valid  <= 1'b0;
            dec_accept <= 1'b0;
            dec_miss   <= 1'b0;
        end else begin
            dec_valid  <= dv_d;
            dec_accept <= acc_d;
            dec_miss   <= miss_d;
        end
    end

    // R2
    sixth_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && pos == LAST_POS) |=> dec_valid);

    // R6
    short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (take && in_eof && pos < LAST_POS) |=> (dec_valid && dec_miss));

    // R7
    reject_is_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !dec_accept) |-> dec_miss);

    // R8
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_ADDR && !start) |=> $stable(mode_q));

    // R10
    idle_no_decision_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !dec_valid);
endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] ST_HI = 16'h0211;
    localparam logic [31:0] ST_LO = 32'h22334455;
    localparam logic [47:0] A_ST  = {ST_HI, ST_LO};
    localparam logic [47:0] A_MCH = 48'h01005E000001;
    localparam int NV = 16;
    // {address, byte count, {promisc, ind_hash, no_bcast}}
    localparam logic [54:0] VECS [0:NV-1] = '{
        {A_ST,            4'd8, 3'b000},
        {48'h021122334456, 4'd8, 3'b000},
        {48'h031122334455, 4'd8, 3'b000},
        {48'hFFFFFFFFFFFF, 4'd8, 3'b000},
        {48'hFFFFFFFFFFFF, 4'd8, 3'b001},
        {48'hFFFFFFFFFFFF, 4'd7, 3'b101},
        {A_MCH,           4'd8, 3'b000},
        {48'h01005E7FFFFA, 4'd8, 3'b000},
        {48'h3355AA010203, 4'd8, 3'b000},
        {A_ST,            4'd8, 3'b010},
        {48'h021122334456, 4'd8, 3'b010},
        {48'h021122334456, 4'd8, 3'b100},
        {A_ST,            4'd3, 3'b000},
        {A_ST,            4'd5, 3'b100},
        {A_ST,            4'd6, 3'b000},
        {48'hFFFFFFFFFFFF, 4'd5, 3'b000}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
    logic [7:0] in_byte = '0;
    logic mode_no_bcast = 1'b0, mode_ind_hash = 1'b0, mode_promisc = 1'b0;
    logic [63:0] hash_tab = '0;
    logic dec_valid, dec_accept, dec_miss;

    int n_chk = 0, n_fail = 0, pulses = 0;
    logic last_acc = 1'b0, last_miss = 1'b0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_addr_filter u_rx_addr_filter (
        .clk, .rst_n, .in_valid, .in_sof, .in_eof, .in_byte,
        .station_hi(ST_HI), .station_lo(ST_LO),
        .hash_lo(hash_tab[31:0]), .hash_hi(hash_tab[63:32]),
        .mode_no_bcast, .mode_ind_hash, .mode_promisc,
        .dec_valid, .dec_accept, .dec_miss
    );

    always @(negedge clk) begin
        if (rst_n && dec_valid) begin
            pulses++;
            last_acc  = dec_accept;
            last_miss = dec_miss;
        end
    end

    function automatic logic [5:0] hash_index(input logic [47:0] a);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int k = 0; k < 6; k++) begin
            c ^= {24'd0, a[47-8*k -: 8]};
            for (int j = 0; j < 8; j++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        c = ~c;
        return c[31:26];
    endfunction

    function automatic logic [1:0] model(input logic [47:0] a, input int len, input logic [2:0] md);
        logic miss;
        if (len < 6)                        miss = 1'b1;
        else if (a == 48'hFFFFFFFFFFFF)     miss = md[0];
        else if (a[40] || md[1])            miss = !hash_tab[hash_index(a)];
        else                                miss = (a != A_ST);
        return {(!miss) || md[2], miss};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b, input logic s, input logic e, input logic [2:0] md);
        in_valid = 1'b1; in_sof = s; in_eof = e; in_byte = b;
        {mode_promisc, mode_ind_hash, mode_no_bcast} = md;
    endtask

    task automatic idle();
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    endtask

    function automatic logic [7:0] byte_of(input logic [47:0] a, input int i);
        return (i < 6) ? a[47-8*i -: 8] : 8'h55;
    endfunction

    task automatic run_frame(input logic [47:0] a, input int len, input logic [2:0] md,
                             output logic on_time);
        int dpos = (len >= 6) ? 5 : len - 1;
        pulses = 0;
        on_time = 1'b0;
        for (int i = 0; i < len + 2; i++) begin
            @(negedge clk);
            if (i == dpos + 1) on_time = dec_valid;
            if (i < len) put(byte_of(a, i), i == 0, i == len - 1, md);
            else idle();
        end
        #1;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic on_time;
        hash_tab[hash_index(A_MCH)] = 1'b1;
        hash_tab[hash_index(A_ST)]  = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 dec_valid", {31'd0, dec_valid}, 0);
        chk("R1 outputs", {30'd0, dec_accept, dec_miss}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after release", {29'd0, dec_valid, dec_accept, dec_miss}, 0);

        for (int v = 0; v < NV; v++) begin
            logic [47:0] a = VECS[v][54:7];
            int len = int'(VECS[v][6:3]);
            logic [2:0] md = VECS[v][2:0];
            string tag;
            if (len < 6) tag = "R6";
            else if (a == 48'hFFFFFFFFFFFF) tag = "R3";
            else if (a[40] || md[1]) tag = "R4";
            else tag = "R5";
            if (md[2]) tag = {tag, "/R7"};
            run_frame(a, len, md, on_time);
            chk("R2 decision cycle", {31'd0, on_time}, 1);
            chk("R2 one decision", pulses, 1);
            chk(tag, {30'd0, last_acc, last_miss}, {30'd0, model(a, len, md)});
        end

        // R8: promiscuous raised after byte 1 does not rescue a miss
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            put(byte_of(48'h021122334466, i), i == 0, i == 7, (i < 2) ? 3'b000 : 3'b100);
        end
        @(negedge clk); idle(); @(negedge clk); #1;
        chk("R8 late promisc", {29'd0, pulses == 1, last_acc, last_miss}, {29'd0, 3'b101});

        // R8: promiscuous dropped after byte 1 still applies
        pulses = 0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            put(byte_of(48'h021122334466, i), i == 0, i == 7, (i < 2) ? 3'b100 : 3'b000);
        end
        @(negedge clk); idle(); @(negedge clk); #1;
        chk("R8 early promisc", {29'd0, pulses == 1, last_acc, last_miss}, {29'd0, 3'b111});

        // R9: restart mid-address
        pulses = 0;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); put(8'hFF, i == 0, 1'b0, 3'b001);
        end
        for (int i = 0; i < 8; i++) begin
            @(negedge clk); put(byte_of(A_ST, i), i == 0, i == 7, 3'b000);
        end
        @(negedge clk); idle(); @(negedge clk); #1;
        chk("R9 restart", {29'd0, pulses == 1, last_acc, last_miss}, {29'd0, 3'b110});

        // R10: idle cycles between bytes
        pulses = 0;
        for (int i = 0; i < 7; i++) begin
            @(negedge clk); put(byte_of(A_ST, i), i == 0, i == 6, 3'b000);
            @(negedge clk); idle();
            @(negedge clk);
            if (i < 5) chk("R10 no early decision", pulses, 0);
        end
        #1;
        chk("R10 gapped frame", {29'd0, pulses == 1, last_acc, last_miss}, {29'd0, 3'b110});

        // R2: bytes with no start marker after a frame make no decision
        pulses = 0;
        for (int i = 0; i < 9; i++) begin
            @(negedge clk); put(8'hFF, 1'b0, i == 8, 3'b000);
        end
        @(negedge clk); idle(); @(negedge clk); #1;
        chk("R2 no sof no decision", pulses, 0);

        // R6: single-byte frame with promiscuous
        run_frame(A_ST, 1, 3'b100, on_time);
        chk("R6 one byte timing", {31'd0, on_time}, 1);
        chk("R6/R7 one byte", {30'd0, last_acc, last_miss}, {30'd0, 2'b11});

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule